// File: doc/BRIEF.md
# Split-Row Threshold Check-Node Partition

This block is one slice of a MinSum check node whose parity-check row has been cut into several partitions. The slice sees only the variable-to-check messages of its own variable nodes. It searches its own inputs for the smallest and second-smallest magnitudes and tells its peer slices two things over one-bit wires: whether its smallest magnitude falls below a fixed threshold T, and the XOR of its local signs. From its peers it takes the same two bits back and forms one check-to-variable message per input.

The magnitude of every outgoing message comes from local data only. A peer that reports a small minimum cannot send its value across. It can only cap the local result at T. The two exported bits are combinational functions of the current inputs, so every partition of a row can exchange them in the same cycle in which the messages are strobed in. The outgoing messages are registered and appear one clock later. The block is evaluated once per decoding iteration, with up to 15 iterations per frame, and holds its last result between strobes.

Messages are 6-bit sign-magnitude values with 2 fractional bits. T is a parameter in the same format. The default of 1 is 0.2 rounded to the nearest quarter.

Top module: `scnp_partition`

## Requirements
- R1: `thr_flag_o` is 1 exactly when the smallest magnitude among the current `msg_in` lanes is strictly below `THR_MAG`. A minimum equal to `THR_MAG` gives 0. The flag is combinational from `msg_in`.
- R2: `sign_o` equals the XOR of the sign bits (bit 5) of all current `msg_in` lanes. It is combinational.
- R3: Each message is 6 bits: bit 5 is the sign and bits 4:0 are an unsigned magnitude with 2 fractional bits. Lane k occupies bits 6k+5:6k. When no `peer_flag_i` bit is set, the output magnitude of lane k is the smallest input magnitude among all local lanes other than k. The lane holding the minimum therefore gets the second-smallest, and on ties every lane gets the tied minimum.
- R4: When any `peer_flag_i` bit is set, the output magnitude of lane k is the smaller of the R3 value and `THR_MAG`.
- R5: The output sign of lane k is the XOR of the sign bits of all other local lanes and of all `peer_sign_i` bits.
- R6: `out_valid` is 1 in exactly the cycles that follow a cycle with `in_valid` high. `msg_out` then carries the result for the inputs sampled at that strobe.
- R7: In a cycle without `in_valid`, changes on `msg_in`, `peer_flag_i` and `peer_sign_i` do not alter `msg_out`, which keeps its last value.
- R8: A synchronous active-high `rst` clears `out_valid` and `msg_out` to 0 at the next edge, even if `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: sample inputs this cycle |
| msg_in | input | NUM_IN*6 | Variable-to-check messages, lane k at bits 6k+5:6k |
| peer_flag_i | input | NUM_PEERS | Below-threshold flags from the other partitions |
| peer_sign_i | input | NUM_PEERS | Sign parities from the other partitions |
| thr_flag_o | output | 1 | Local minimum is below T (to peers) |
| sign_o | output | 1 | XOR of local signs (to peers) |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| msg_out | output | NUM_IN*6 | Check-to-variable messages, same lane layout |

## Verification
A wrong minimum index or a lost second minimum shows on the very next `out_valid`. The lane that holds the minimum then receives its own magnitude, or a lane next to it receives the second-smallest, so the sweep places the minimum at every lane position and at every magnitude. A wrong threshold comparison shows in the same cycle on `thr_flag_o`. A wrong cap shows one cycle later, on every lane whose magnitude exceeds T. The sweep therefore pairs magnitudes just below, at and above T with every peer-flag pattern. A register that loads without a strobe shows as a changed `msg_out` during idle cycles in which the inputs are deliberately disturbed.

// File: rtl/scnp_pkg.sv
package scnp_pkg;
    localparam int unsigned MSG_W = 6;
    localparam int unsigned MAG_W = MSG_W - 1;

    typedef logic [MSG_W-1:0] msg_t;
    typedef logic [MAG_W-1:0] mag_t;

    function automatic mag_t mag_of(msg_t m);
        return m[MAG_W-1:0];
    endfunction

    function automatic logic sign_of(msg_t m);
        return m[MSG_W-1];
    endfunction
endpackage

// File: rtl/scnp_min2.sv
module scnp_min2
    import scnp_pkg::*;
#(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*MAG_W-1:0] mags_i,
    output mag_t               min1_o,
    output mag_t               min2_o,
    output logic [IDX_W-1:0]   idx_o
);
    always_comb begin
        mag_t cur;
        min1_o = '1;
        min2_o = '1;
        idx_o  = '0;
        for (int k = 0; k < int'(N); k++) begin
            cur = mags_i[k*MAG_W +: MAG_W];
            if (cur < min1_o) begin
                min2_o = min1_o;
                min1_o = cur;
                idx_o  = IDX_W'(k);
            end else if (cur < min2_o) begin
                min2_o = cur;
            end
        end
    end
endmodule

// File: rtl/scnp_lane.sv
module scnp_lane
    import scnp_pkg::*;
#(
    parameter int unsigned THR_MAG = 1
) (
    input  logic own_sign_i,
    input  mag_t min1_i,
    input  mag_t min2_i,
    input  logic is_min_i,
    input  logic cap_i,
    input  logic sign_rest_i,
    output msg_t msg_o
);
    localparam mag_t THR = mag_t'(THR_MAG);

    mag_t base;
    mag_t capped;

    always_comb begin
        base   = is_min_i ? min2_i : min1_i;
        capped = (cap_i && (base > THR)) ? THR : base;
        msg_o  = {sign_rest_i ^ own_sign_i, capped};
    end
endmodule

// File: rtl/scnp_partition.sv
module scnp_partition
    import scnp_pkg::*;
#(
    parameter int unsigned NUM_IN    = 8,
    parameter int unsigned NUM_PEERS = 3,
    parameter int unsigned THR_MAG   = 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [NUM_IN*MSG_W-1:0]   msg_in,
    input  logic [NUM_PEERS-1:0]      peer_flag_i,
    input  logic [NUM_PEERS-1:0]      peer_sign_i,
    output logic                      thr_flag_o,
    output logic                      sign_o,
    output logic                      out_valid,
    output logic [NUM_IN*MSG_W-1:0]   msg_out
);
    localparam int unsigned IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;
    localparam int unsigned BUS_W = NUM_IN * MSG_W;
    localparam mag_t        THR   = mag_t'(THR_MAG);

    typedef struct packed {
        logic             vld;
        logic [BUS_W-1:0] msg;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_IN*MAG_W-1:0] mags;
    logic [NUM_IN-1:0]       signs;
    logic [BUS_W-1:0]        lane_msg;
    mag_t                    min1, min2;
    logic [IDX_W-1:0]        min_idx;
    logic                    local_par;
    logic                    sign_rest;
    logic                    cap;

    for (genvar g = 0; g < int'(NUM_IN); g++) begin : g_split
        assign mags[g*MAG_W +: MAG_W] = mag_of(msg_in[g*MSG_W +: MSG_W]);
        assign signs[g]               = sign_of(msg_in[g*MSG_W +: MSG_W]);
    end

    scnp_min2 #(.N(NUM_IN), .IDX_W(IDX_W)) u_min2 (
        .mags_i (mags),
        .min1_o (min1),
        .min2_o (min2),
        .idx_o  (min_idx)
    );

    assign local_par = ^signs;
    assign sign_rest = local_par ^ (^peer_sign_i);
    assign cap       = |peer_flag_i;

    for (genvar g = 0; g < int'(NUM_IN); g++) begin : g_lane
        scnp_lane #(.THR_MAG(THR_MAG)) u_lane (
            .own_sign_i  (signs[g]),
            .min1_i      (min1),
            .min2_i      (min2),
            .is_min_i    (min_idx == IDX_W'(g)),
            .cap_i       (cap),
            .sign_rest_i (sign_rest),
            .msg_o       (lane_msg[g*MSG_W +: MSG_W])
        );
    end

    assign thr_flag_o = (min1 < THR);
    assign sign_o     = local_par;

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.msg = lane_msg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign msg_out   = st_q.msg;
endmodule

// File: rtl/scnp_partition_chk.sv
module scnp_partition_chk
    import scnp_pkg::*;
#(
    parameter int unsigned NUM_IN    = 8,
    parameter int unsigned NUM_PEERS = 3,
    parameter int unsigned THR_MAG   = 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic [NUM_IN*MSG_W-1:0] msg_in,
    input logic [NUM_PEERS-1:0]    peer_flag_i,
    input logic [NUM_PEERS-1:0]    peer_sign_i,
    input logic                    thr_flag_o,
    input logic                    sign_o,
    input logic                    out_valid,
    input logic [NUM_IN*MSG_W-1:0] msg_out
);
    localparam mag_t THR = mag_t'(THR_MAG);

    logic any_below;
    mag_t in_min;
    logic out_le_thr;
    logic out_ge_min;
    logic cap_q;
    mag_t min_q;

    always_comb begin
        any_below = 1'b0;
        in_min    = '1;
        for (int k = 0; k < int'(NUM_IN); k++) begin
            if (mag_of(msg_in[k*MSG_W +: MSG_W]) < THR) any_below = 1'b1;
            if (mag_of(msg_in[k*MSG_W +: MSG_W]) < in_min) in_min = mag_of(msg_in[k*MSG_W +: MSG_W]);
        end
    end

    always_comb begin
        out_le_thr = 1'b1;
        out_ge_min = 1'b1;
        for (int k = 0; k < int'(NUM_IN); k++) begin
            if (mag_of(msg_out[k*MSG_W +: MSG_W]) > THR)   out_le_thr = 1'b0;
            if (mag_of(msg_out[k*MSG_W +: MSG_W]) < min_q) out_ge_min = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= 1'b0;
            min_q <= '0;
        end else if (in_valid) begin
            cap_q <= |peer_flag_i;
            min_q <= in_min;
        end
    end

    AST_FLAG_BELOW: assert property (@(posedge clk) disable iff (rst) thr_flag_o == any_below); // R1
    AST_NOCAP_FLOOR: assert property (@(posedge clk) disable iff (rst) (out_valid && !cap_q) |-> out_ge_min); // R3
    AST_CAP_CEIL: assert property (@(posedge clk) disable iff (rst) (out_valid && cap_q) |-> out_le_thr); // R4
    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R6
    AST_VALID_ONLY: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(msg_out)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && (msg_out == '0))); // R8

    logic unused_ok;
    assign unused_ok = ^{sign_o, peer_sign_i};
endmodule

bind scnp_partition scnp_partition_chk #(
    .NUM_IN    (NUM_IN),
    .NUM_PEERS (NUM_PEERS),
    .THR_MAG   (THR_MAG)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .msg_in      (msg_in),
    .peer_flag_i (peer_flag_i),
    .peer_sign_i (peer_sign_i),
    .thr_flag_o  (thr_flag_o),
    .sign_o      (sign_o),
    .out_valid   (out_valid),
    .msg_out     (msg_out)
);

// File: tb/scnp_partition_tb.sv
`timescale 1ns/1ps
module scnp_partition_tb;
    localparam int N  = 4;
    localparam int P  = 2;
    localparam int T  = 6;
    localparam int MW = 6;
    localparam int AW = 5;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid;
    logic [N*MW-1:0] msg_in;
    logic [P-1:0]    peer_flag_i;
    logic [P-1:0]    peer_sign_i;
    logic            thr_flag_o;
    logic            sign_o;
    logic            out_valid;
    logic [N*MW-1:0] msg_out;

    int checks = 0;
    int errs   = 0;

    always #4 clk = ~clk;

    scnp_partition #(.NUM_IN(N), .NUM_PEERS(P), .THR_MAG(T)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .msg_in(msg_in),
        .peer_flag_i(peer_flag_i), .peer_sign_i(peer_sign_i),
        .thr_flag_o(thr_flag_o), .sign_o(sign_o),
        .out_valid(out_valid), .msg_out(msg_out)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Caller is at a negedge; returns at a negedge one cycle later.
    task automatic apply(input logic [N*MW-1:0] m, input logic [P-1:0] f, input logic [P-1:0] s);
        int mn;
        int par;
        int exp_mag [N];
        int exp_sgn [N];
        msg_in = m; peer_flag_i = f; peer_sign_i = s; in_valid = 1'b1;
        #1;
        mn = 31; par = 0;
        for (int j = 0; j < N; j++) begin
            if (int'(m[j*MW +: AW]) < mn) mn = int'(m[j*MW +: AW]);
            par ^= int'(m[j*MW + AW]);
        end
        chk(thr_flag_o == (mn < T), "R1", "threshold flag", int'(thr_flag_o), int'(mn < T));
        chk(sign_o == par[0], "R2", "sign parity", int'(sign_o), par);
        for (int i = 0; i < N; i++) begin
            exp_mag[i] = 31;
            exp_sgn[i] = int'(^s);
            for (int j = 0; j < N; j++) begin
                if (j != i) begin
                    if (int'(m[j*MW +: AW]) < exp_mag[i]) exp_mag[i] = int'(m[j*MW +: AW]);
                    exp_sgn[i] ^= int'(m[j*MW + AW]);
                end
            end
            if ((|f) && exp_mag[i] > T) exp_mag[i] = T;
        end
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R6", "out_valid after strobe", int'(out_valid), 1);
        for (int i = 0; i < N; i++) begin
            if (|f)
                chk(int'(msg_out[i*MW +: AW]) == exp_mag[i], "R4", $sformatf("lane %0d capped mag", i), int'(msg_out[i*MW +: AW]), exp_mag[i]);
            else
                chk(int'(msg_out[i*MW +: AW]) == exp_mag[i], "R3", $sformatf("lane %0d mag", i), int'(msg_out[i*MW +: AW]), exp_mag[i]);
            chk(int'(msg_out[i*MW + AW]) == exp_sgn[i], "R5", $sformatf("lane %0d sign", i), int'(msg_out[i*MW + AW]), exp_sgn[i]);
        end
    endtask

    function automatic logic [N*MW-1:0] pack4(input int m0, input int m1, input int m2, input int m3, input int sg);
        logic [N*MW-1:0] r;
        r = '0;
        r[0*MW +: MW] = {sg[0], AW'(m0)};
        r[1*MW +: MW] = {sg[1], AW'(m1)};
        r[2*MW +: MW] = {sg[2], AW'(m2)};
        r[3*MW +: MW] = {sg[3], AW'(m3)};
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [N*MW-1:0] held;
        logic [N*MW-1:0] m;
        int v [N];
        rst = 1'b1; in_valid = 1'b0; msg_in = '0; peer_flag_i = '0; peer_sign_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
        chk(msg_out == '0, "R8", "msg_out in reset", int'(msg_out), 0);
        rst = 1'b0;

        // R1 boundary: minimum equal to T, one below, one above
        apply(pack4(T, 20, 9, 31, 0), 2'b00, 2'b00);
        apply(pack4(12, T-1, 9, 31, 0), 2'b01, 2'b10);
        apply(pack4(12, T+1, 9, 31, 0), 2'b10, 2'b00);
        // R3 ties for the minimum
        apply(pack4(3, 3, 17, 25, 5), 2'b00, 2'b01);
        apply(pack4(0, 0, 0, 0, 15), 2'b11, 2'b11);
        apply(pack4(31, 31, 31, 31, 0), 2'b00, 2'b00);
        apply(pack4(31, 31, 31, 31, 0), 2'b01, 2'b00);

        // Sweep minimum position, minimum value and peer flags
        for (int pos = 0; pos < N; pos++)
            for (int mv = 0; mv < 32; mv++)
                for (int fl = 0; fl < (1 << P); fl++) begin
                    for (int k = 0; k < N; k++) v[k] = mv + int'($urandom % (32 - mv));
                    v[pos] = mv;
                    apply(pack4(v[0], v[1], v[2], v[3], int'($urandom % 16)), P'(fl), P'($urandom % 4));
                end

        // Sign sweep: every local sign pattern with every peer sign pattern (R2, R5)
        for (int sg = 0; sg < 16; sg++)
            for (int ps = 0; ps < (1 << P); ps++)
                apply(pack4(8, 2, 14, 27, sg), 2'b00, P'(ps));

        // Random traffic
        for (int r = 0; r < 1500; r++) begin
            m = N*MW'({$urandom, $urandom});
            apply(m, P'($urandom % 4), P'($urandom % 4));
        end

        // R7: idle cycles with disturbed inputs leave msg_out unchanged
        held = msg_out;
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            msg_in = N*MW'($urandom); peer_flag_i = P'($urandom % 4); peer_sign_i = P'($urandom % 4);
            @(posedge clk);
            @(negedge clk);
            chk(out_valid == 1'b0, "R6", "no valid without strobe", int'(out_valid), 0);
            chk(msg_out == held, "R7", "msg_out held while idle", int'(msg_out), int'(held));
        end

        // R8: reset wins over a strobe
        apply(pack4(9, 10, 11, 12, 3), 2'b00, 2'b00);
        rst = 1'b1; in_valid = 1'b1; msg_in = pack4(1, 2, 3, 4, 1);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R8", "out_valid after mid-run reset", int'(out_valid), 0);
        chk(msg_out == '0, "R8", "msg_out after mid-run reset", int'(msg_out), 0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule